// File: doc/BRIEF.md
# USB Device Receive CRC Check and Handshake Decision

This block sits in the receive path of a USB device-mode controller, after token decoding and after the PHY, NRZI and bit-unstuffing stages. It takes the bytes of a received DATA packet, meaning the payload followed by its two CRC16 bytes. Packet boundaries arrive on separate start and end strobes, and an endpoint-type input says whether the endpoint is isochronous. The CRC16 is computed while the bytes arrive. Every accepted byte is written into the endpoint receive FIFO at once. At end of packet the block either commits the payload or rolls the FIFO write pointer back to where it stood at start of packet.

The outcome of the CRC check depends on the transfer type:
- A non-isochronous packet with a bad CRC is discarded silently. No handshake goes out, so the host resends.
- An isochronous packet with a bad CRC is kept, and a sticky error flag is raised for software.
- Isochronous traffic never produces a handshake.

The block also answers PING tokens. It replies ACK if the FIFO can take a maximum-size packet and NAK if it cannot. A non-isochronous packet that starts without that room is dropped and answered with NAK.

The byte input is a valid/ready stream. Its ready output is held high: the block never back-pressures, and bytes it cannot store are discarded. The FIFO read side is a valid/ready stream that shows committed payload bytes only. A byte moves on any clock edge where both valid and ready are high. Valid, once raised, stays high until the byte is taken.

Top module: `usbd_rx_commit`

## Requirements
- R1: The CRC16 uses polynomial x^16+x^15+x^2+1. The register is preset to all ones on `rx_sop`, and each byte is shifted in least significant bit first. A packet is good only when the complemented register equals 16'h7FF2 after all payload and CRC bytes have been shifted in. CRC bytes are transmitted low byte first.
- R2: A good non-isochronous packet commits its payload and drives `hs_valid`=1 with `hs_code`=2'b01 (ACK) in the cycle after `rx_eop`.
- R3: A non-isochronous packet with a bad CRC is flushed: none of its bytes ever appear on the FIFO read port, and no handshake is issued.
- R4: A non-isochronous packet with a bad CRC leaves `crc_err` unchanged and does not pulse `pkt_done`.
- R5: An isochronous packet with a bad CRC commits its payload, pulses `pkt_done` and sets `crc_err` in the cycle after `rx_eop`.
- R6: An isochronous packet never produces `hs_valid`, whatever its CRC.
- R7: In the cycle after `ping_stb` on a non-isochronous endpoint, `hs_valid`=1 with `hs_code`=2'b01 (ACK) if free FIFO space is at least MAX_PKT+2 bytes, and 2'b10 (NAK) otherwise. A PING on an isochronous endpoint gets no handshake.
- R8: A packet whose `rx_sop` sees less than MAX_PKT+2 free bytes writes nothing to the FIFO. If non-isochronous, it gets NAK (2'b10) after `rx_eop`. If isochronous, it gets no handshake. In both cases there is no `pkt_done`.
- R9: For every committed packet, `pkt_done` pulses in the cycle after `rx_eop`, and `pkt_len` then holds the number of received bytes minus the two CRC bytes (0 if fewer than two were received).
- R10: `crc_err` stays set until an `err_clr` pulse clears it. A new error in the same cycle as `err_clr` wins.
- R11: The read port presents committed payload bytes in arrival order, never a CRC byte, and never a byte of a packet still in flight.
- R12: After reset, `hs_valid`, `pkt_done`, `crc_err` and `ff_valid` are 0 and `rx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Byte accepted (always 1) |
| rx_data | input | 8 | Received byte |
| rx_sop | input | 1 | Start-of-packet strobe, in a cycle with no byte |
| rx_eop | input | 1 | End-of-packet strobe, in a cycle with no byte |
| ep_iso | input | 1 | Endpoint is isochronous (sampled at `rx_sop` and `ping_stb`) |
| ping_stb | input | 1 | PING token received for this endpoint |
| ff_valid | output | 1 | Committed byte available |
| ff_ready | input | 1 | Reader takes the byte |
| ff_data | output | 8 | Committed byte |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 2'b01 ACK, 2'b10 NAK |
| pkt_done | output | 1 | Packet committed pulse |
| pkt_len | output | $clog2(DEPTH)+1 | Committed payload length |
| crc_err | output | 1 | Sticky isochronous CRC error flag |
| err_clr | input | 1 | Write-one-to-clear pulse for `crc_err` |

## Verification
The assertions assume well-formed framing on the inputs:
- `rx_sop`, `rx_eop`, byte transfers and `ping_stb` each occupy a cycle of their own.
- Every start strobe is matched by an end strobe.
- No PING arrives inside a packet.
- No packet carries more than MAX_PKT payload bytes.

The stimulus is built from tasks that frame each packet in this order and keep payload lengths between 0 and MAX_PKT. Under these rules the FIFO occupancy can never exceed its depth.

// File: rtl/usbd_rx_pkg.sv
package usbd_rx_pkg;

  typedef enum logic [1:0] {
    HS_NONE = 2'b00,
    HS_ACK  = 2'b01,
    HS_NAK  = 2'b10
  } hs_code_e;

  localparam logic [15:0] CRC_POLY   = 16'h8005;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'h7FF2;

  // Register kept with x^15 in bit 15; data enters LSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                             input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = d[i] ^ c[15];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/usbd_crc16.sv
module usbd_crc16
  import usbd_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       en,
  input  logic [7:0] data,
  output logic       crc_ok
);

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= CRC_PRESET;
    else if (init) crc_q <= CRC_PRESET;
    else if (en)   crc_q <= crc16_byte(crc_q, data);
  end

  assign crc_ok = ((~crc_q) == CRC_GOOD);

  // A freshly preset register can never look like a good residue.
  p_fresh_not_good_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !crc_ok);

endmodule

// File: rtl/usbd_ep_fifo.sv
module usbd_ep_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic          rollback,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [PW-1:0] free_cnt,
  output logic [PW-1:0] pend_cnt
);

  localparam logic [PW-1:0] DEPTH_W = PW'(DEPTH);
  localparam logic [PW-1:0] CRC_LEN = PW'(2);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr;
  logic [PW-1:0] used, trim, cm_next;
  logic          do_wr;

  assign used     = wr_ptr - rd_ptr;
  assign free_cnt = DEPTH_W - used;
  assign pend_cnt = wr_ptr - cm_ptr;
  assign trim     = (pend_cnt >= CRC_LEN) ? CRC_LEN : pend_cnt;
  assign cm_next  = wr_ptr - trim;
  assign do_wr    = wr_en && (free_cnt != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      cm_ptr <= '0;
    end else if (rollback) begin
      wr_ptr <= cm_ptr;
    end else if (commit) begin
      wr_ptr <= cm_next;
      cm_ptr <= cm_next;
    end else if (do_wr) begin
      wr_ptr <= wr_ptr + PW'(1);
    end
  end

  assign rd_valid = (rd_ptr != cm_ptr);
  assign rd_data  = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_ptr <= '0;
    else if (rd_valid && rd_ready) rd_ptr <= rd_ptr + PW'(1);
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_W);

  p_flush_keeps_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> (cm_ptr == $past(cm_ptr)));

  p_commit_behind_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_ptr - rd_ptr) <= used);

  p_single_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && rollback));

endmodule

// File: rtl/usbd_rx_ctrl.sv
module usbd_rx_ctrl
  import usbd_rx_pkg::*;
#(
  parameter int MAX_PKT = 16,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sop,
  input  logic          eop,
  input  logic          byte_fire,
  input  logic          iso,
  input  logic          ping,
  input  logic          crc_ok,
  input  logic [PW-1:0] free_cnt,
  input  logic [PW-1:0] pend_cnt,
  input  logic          err_clr,
  output logic          crc_init,
  output logic          crc_en,
  output logic          fifo_wr,
  output logic          commit,
  output logic          rollback,
  output logic          hs_valid,
  output hs_code_e      hs_code,
  output logic          pkt_done,
  output logic [PW-1:0] pkt_len,
  output logic          err_flag
);

  localparam logic [PW-1:0] ROOM    = PW'(MAX_PKT + 2);
  localparam logic [PW-1:0] CRC_LEN = PW'(2);

  logic          in_pkt, refuse_q, iso_q, has_room, eop_live, accept, iso_bad;
  logic [PW-1:0] len_now;

  assign has_room = (free_cnt >= ROOM);
  assign eop_live = eop && in_pkt;
  assign accept   = byte_fire && in_pkt && !refuse_q;
  assign crc_init = sop;
  assign crc_en   = accept;
  assign fifo_wr  = accept;
  assign commit   = eop_live && !refuse_q && (iso_q || crc_ok);
  assign rollback = eop_live && !refuse_q && !iso_q && !crc_ok;
  assign iso_bad  = eop_live && !refuse_q && iso_q && !crc_ok;
  assign len_now  = (pend_cnt >= CRC_LEN) ? (pend_cnt - CRC_LEN) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      refuse_q <= 1'b0;
      iso_q    <= 1'b0;
    end else if (sop) begin
      in_pkt   <= 1'b1;
      refuse_q <= !has_room;
      iso_q    <= iso;
    end else if (eop) begin
      in_pkt   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
    end else begin
      hs_valid <= 1'b0;
      hs_code  <= HS_NONE;
      if (eop_live && !iso_q && (refuse_q || crc_ok)) begin
        hs_valid <= 1'b1;
        hs_code  <= refuse_q ? HS_NAK : HS_ACK;
      end else if (ping && !iso && !in_pkt) begin
        hs_valid <= 1'b1;
        hs_code  <= has_room ? HS_ACK : HS_NAK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done <= 1'b0;
      pkt_len  <= '0;
      err_flag <= 1'b0;
    end else begin
      pkt_done <= commit;
      if (commit)       pkt_len  <= len_now;
      if (iso_bad)      err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
    end
  end

  p_iso_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_live && iso_q) |=> !hs_valid);

  p_flush_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> (!$rose(err_flag) && !pkt_done));

  p_ack_needs_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == HS_ACK && $past(eop_live)) |-> $past(crc_ok));

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  p_refused_nak_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_live && refuse_q && !iso_q) |=> (hs_valid && hs_code == HS_NAK && !pkt_done));

endmodule

// File: rtl/usbd_rx_commit.sv
module usbd_rx_commit
  import usbd_rx_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rx_valid,
  output logic                   rx_ready,
  input  logic [7:0]             rx_data,
  input  logic                   rx_sop,
  input  logic                   rx_eop,
  input  logic                   ep_iso,
  input  logic                   ping_stb,
  output logic                   ff_valid,
  input  logic                   ff_ready,
  output logic [7:0]             ff_data,
  output logic                   hs_valid,
  output logic [1:0]             hs_code,
  output logic                   pkt_done,
  output logic [$clog2(DEPTH):0] pkt_len,
  output logic                   crc_err,
  input  logic                   err_clr
);

  localparam int PW = $clog2(DEPTH) + 1;

  logic          crc_init, crc_en, crc_ok;
  logic          fifo_wr, commit, rollback;
  logic [PW-1:0] free_cnt, pend_cnt;
  hs_code_e      hs_code_e_w;

  assign rx_ready = 1'b1;
  assign hs_code  = hs_code_e_w;

  usbd_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (crc_init),
    .en     (crc_en),
    .data   (rx_data),
    .crc_ok (crc_ok)
  );

  usbd_ep_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fifo_wr),
    .wr_data  (rx_data),
    .commit   (commit),
    .rollback (rollback),
    .rd_ready (ff_ready),
    .rd_valid (ff_valid),
    .rd_data  (ff_data),
    .free_cnt (free_cnt),
    .pend_cnt (pend_cnt)
  );

  usbd_rx_ctrl #(.MAX_PKT(MAX_PKT), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sop       (rx_sop),
    .eop       (rx_eop),
    .byte_fire (rx_valid && rx_ready),
    .iso       (ep_iso),
    .ping      (ping_stb),
    .crc_ok    (crc_ok),
    .free_cnt  (free_cnt),
    .pend_cnt  (pend_cnt),
    .err_clr   (err_clr),
    .crc_init  (crc_init),
    .crc_en    (crc_en),
    .fifo_wr   (fifo_wr),
    .commit    (commit),
    .rollback  (rollback),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code_e_w),
    .pkt_done  (pkt_done),
    .pkt_len   (pkt_len),
    .err_flag  (crc_err)
  );

endmodule

// File: tb/usbd_rx_commit_bench.sv
module usbd_rx_commit_bench;

  localparam int DEPTH   = 16;
  localparam int MAX_PKT = 6;
  localparam int LW      = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
  logic          ep_iso = 1'b0, ping_stb = 1'b0, ff_ready = 1'b0, err_clr = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, ff_valid, hs_valid, pkt_done, crc_err;
  logic [7:0]    ff_data;
  logic [1:0]    hs_code;
  logic [LW-1:0] pkt_len;

  int            n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0]    pl [0:15];
  logic [7:0]    expq [$];

  always #5 clk = ~clk;

  usbd_rx_commit #(.DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_usbd_rx_commit (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sop(rx_sop), .rx_eop(rx_eop), .ep_iso(ep_iso),
    .ping_stb(ping_stb), .ff_valid(ff_valid), .ff_ready(ff_ready),
    .ff_data(ff_data), .hs_valid(hs_valid), .hs_code(hs_code),
    .pkt_done(pkt_done), .pkt_len(pkt_len), .crc_err(crc_err), .err_clr(err_clr)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reflected reference form of the bus CRC16, complemented for transmit.
  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      r = r ^ {8'h00, pl[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return ~r;
  endfunction

  task automatic send_pkt(int n, bit iso, bit bad, bit clr);
    logic [15:0] c;
    c = ref_crc(n);
    pl[n]   = c[7:0];
    pl[n+1] = c[15:8] ^ (bad ? 8'h01 : 8'h00);
    @(negedge clk); rx_sop = 1'b1; ep_iso = iso;
    @(negedge clk); rx_sop = 1'b0;
    for (int i = 0; i < n + 2; i++) begin
      rx_valid = 1'b1; rx_data = pl[i];
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_eop = 1'b1; err_clr = clr;
    @(negedge clk); rx_eop = 1'b0; err_clr = 1'b0;
  endtask

  task automatic push_exp(int n);
    for (int i = 0; i < n; i++) expq.push_back(pl[i]);
  endtask

  task automatic drain(string req);
    int guard = 0;
    ff_ready = 1'b1;
    while (ff_valid && guard < 40) begin
      if (expq.size() == 0) chk({req, " extra byte"}, 1, 0);
      else chk({req, " data"}, int'(ff_data), int'(expq.pop_front()));
      guard++;
      @(negedge clk);
    end
    ff_ready = 1'b0;
    chk({req, " missing bytes"}, expq.size(), 0);
    expq.delete();
  endtask

  task automatic ping(bit iso, bit exp_v, int exp_code, string req);
    @(negedge clk); ping_stb = 1'b1; ep_iso = iso;
    @(negedge clk); ping_stb = 1'b0;
    chk({req, " ping hs_valid"}, int'(hs_valid), int'(exp_v));
    if (exp_v) chk({req, " ping hs_code"}, int'(hs_code), exp_code);
  endtask

  task automatic clear_flag();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk("R10 cleared by err_clr", int'(crc_err), 0);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 hs_valid", int'(hs_valid), 0);
    chk("R12 pkt_done", int'(pkt_done), 0);
    chk("R12 crc_err",  int'(crc_err), 0);
    chk("R12 ff_valid", int'(ff_valid), 0);
    chk("R12 rx_ready", int'(rx_ready), 1);

    // Sweep: length x type x CRC outcome, empty FIFO each time (R1-R6, R9, R11)
    for (int len = 0; len <= MAX_PKT; len++)
      for (int iso = 0; iso < 2; iso++)
        for (int bad = 0; bad < 2; bad++) begin
          bit keep;
          for (int i = 0; i < len; i++) pl[i] = 8'((len * 37 + i * 13 + iso * 5 + bad) & 255);
          send_pkt(len, iso[0], bad[0], 1'b0);
          keep = (iso != 0) || (bad == 0);
          // R2 / R3 / R6: handshake only for good non-isochronous packets
          chk("R2 R3 R6 hs_valid", int'(hs_valid), int'(iso == 0 && bad == 0));
          if (iso == 0 && bad == 0) chk("R2 hs_code ACK", int'(hs_code), 1);
          // R4 / R5 / R9
          chk("R4 R5 R9 pkt_done", int'(pkt_done), int'(keep));
          if (keep) chk("R9 pkt_len", int'(pkt_len), len);
          chk("R4 R5 crc_err", int'(crc_err), int'(iso != 0 && bad != 0));
          // R3 / R11: flushed packet exposes nothing
          chk("R3 R11 ff_valid after eop", int'(ff_valid), int'(keep && len > 0));
          if (keep) push_exp(len);
          drain("R11 R3 read port");
          if (crc_err) clear_flag();
        end

    // R10: sticky across a later good packet, and set wins over clear
    for (int i = 0; i < 3; i++) pl[i] = 8'(8'hA0 + i);
    send_pkt(3, 1'b1, 1'b1, 1'b0);
    chk("R5 flag set", int'(crc_err), 1);
    send_pkt(2, 1'b0, 1'b0, 1'b0);
    chk("R10 flag held", int'(crc_err), 1);
    expq.delete(); ff_ready = 1'b1; repeat (12) @(negedge clk); ff_ready = 1'b0;
    clear_flag();
    send_pkt(3, 1'b1, 1'b1, 1'b1);
    chk("R10 set wins over clear", int'(crc_err), 1);
    expq.delete(); ff_ready = 1'b1; repeat (12) @(negedge clk); ff_ready = 1'b0;
    clear_flag();
    chk("R11 empty before fill test", int'(ff_valid), 0);

    // R7 / R8: room tracking with MAX_PKT + 2 = 8 needed of 16
    ping(1'b0, 1'b1, 1, "R7 room");
    ping(1'b1, 1'b0, 0, "R7 iso");
    for (int i = 0; i < MAX_PKT; i++) pl[i] = 8'(8'h10 + i);
    send_pkt(MAX_PKT, 1'b0, 1'b0, 1'b0); push_exp(MAX_PKT);
    chk("R2 first ACK", int'(hs_code), 1);
    ping(1'b0, 1'b1, 1, "R7 ten free");
    for (int i = 0; i < MAX_PKT; i++) pl[i] = 8'(8'h40 + i);
    send_pkt(MAX_PKT, 1'b0, 1'b0, 1'b0); push_exp(MAX_PKT);
    chk("R2 second ACK", int'(hs_code), 1);
    ping(1'b0, 1'b1, 2, "R7 four free NAK");
    for (int i = 0; i < 3; i++) pl[i] = 8'(8'h70 + i);
    send_pkt(3, 1'b0, 1'b0, 1'b0);
    chk("R8 refused hs_valid", int'(hs_valid), 1);
    chk("R8 refused NAK", int'(hs_code), 2);
    chk("R8 refused no pkt_done", int'(pkt_done), 0);
    send_pkt(3, 1'b1, 1'b0, 1'b0);
    chk("R8 iso refused silent", int'(hs_valid), 0);
    chk("R8 iso refused no pkt_done", int'(pkt_done), 0);
    drain("R11 R8 order after refusals");
    ping(1'b0, 1'b1, 1, "R7 room again");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule